// File: doc/BRIEF.md
# Home-Node Directory Coherence Request Controller

This block sits at the home node of a multiprocessor and decides, one request at a time, how a whole cache line moves between processors. A request names the processor asking, the line, and whether it wants a shared copy or exclusive ownership. For every line the block keeps a directory entry: an owner (possibly none) and a bit-vector of processors that hold copies. The directory is the single point where requests to a line are put in order. The entry is updated in the same cycle the request is accepted.

For each request the block emits a short, fixed sequence of one-cycle messages on three output channels. The message channel carries invalidates and forwarded reads. The data channel tells memory to deliver the line to the requester. The commit channel tells the requester that its request has been ordered. Invalidates are never acknowledged. An owner that loses ownership hands its data over directly, so the block never asks for a writeback. Ownership can therefore pass along a chain of exclusive requesters, and each new one is forwarded to the latest owner. The invalidates go out first, in ascending processor index. The data or forward comes next, then the commit, one message per cycle with no gaps.

Top module: `dircoh_ctrl`

## Requirements
- R1: After reset, req_ready is 1, no output channel is valid, and every line has no owner and an empty copies set. The first request to any line is therefore served with memory data and no invalidate.
- R2: A shared read (req_excl=0) to a line with no owner produces one data-channel message to the requester, followed by the commit. The requester joins the copies set and the line stays without an owner.
- R3: A shared read to a line owned by a different processor sends a forwarded read (msg_kind=0) to the owner, with msg_req set to the requester. No memory data is sent. The owner keeps ownership and the requester joins the copies set.
- R4: An exclusive read (req_excl=1) sends an invalidate (msg_kind=2) to every processor in the copies set other than the requester and the current owner. It never waits for any acknowledgement. Afterwards the requester is the owner and the only member of the copies set.
- R5: An exclusive read to a line owned by a different processor sends a forwarded exclusive read (msg_kind=1) to that owner and no memory data. With no owner, the line comes from memory on the data channel.
- R6: The messages for one request follow this order: invalidates in ascending processor index, then the data or forward message, then the commit. At most one channel is valid per cycle, and msg_kind 3 never appears. The first message is valid in the cycle after acceptance, and the rest follow back to back.
- R7: A request from the processor that already owns the line sends no data and no forward. A shared read gets only the commit. An exclusive read gets the invalidates of R4 and then the commit.
- R8: The block accepts one request at a time. req_ready is 0 from the cycle after acceptance through the commit cycle, and is 1 again in the cycle after the commit. No output is valid while req_ready is 1.
- R9: Successive exclusive reads to one line from different processors form a chain. Each one is forwarded to the processor that took ownership in the previous request.
- R10: A request changes only the directory entry of its own line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_id | input | PID_W | Requesting processor index |
| req_adr | input | ADR_W | Line index |
| req_excl | input | 1 | 1 = exclusive read, 0 = shared read |
| msg_valid | output | 1 | Message channel valid |
| msg_kind | output | 2 | 0 forwarded read, 1 forwarded exclusive, 2 invalidate |
| msg_dest | output | PID_W | Processor receiving the message |
| msg_req | output | PID_W | Requester the message is on behalf of |
| msg_adr | output | ADR_W | Line of the message |
| dat_valid | output | 1 | Memory data to be delivered |
| dat_dest | output | PID_W | Processor receiving the memory data |
| dat_adr | output | ADR_W | Line to read from memory |
| cmt_valid | output | 1 | Commit valid |
| cmt_dest | output | PID_W | Processor receiving the commit |
| cmt_adr | output | ADR_W | Line committed |

## Verification
Directed sequences on a single line walk through every directory state. They cover shared reads with and without an owner and exclusive reads over several sharers. They also cover a chain of exclusive takeovers and repeat requests from the owner. Together these separate the memory, forward and commit-only outcomes, and they exercise the rule that the owner is skipped when invalidates are sent. Requests to an untouched line and to the last line show that entries are kept apart and come out of reset empty. A long run of random requests over a few lines checks every message of every request, in order, against a reference directory model. That run builds up dense copies sets and so exercises the ascending order of the invalidates.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;
   typedef enum logic [1:0] {
      MK_FWD_RD = 2'd0,
      MK_FWD_EX = 2'd1,
      MK_INVAL  = 2'd2
   } msg_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_INV  = 2'd1,
      SQ_DATA = 2'd2,
      SQ_CMT  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/dircoh_store.sv
module dircoh_store #(
   parameter int N_PROC = 4,
   parameter int N_LINE = 16,
   localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int ADR_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADR_W-1:0]  rd_adr,
   output logic              rd_own_vld,
   output logic [PID_W-1:0]  rd_own_id,
   output logic [N_PROC-1:0] rd_copies,
   input  logic              wr_en,
   input  logic [ADR_W-1:0]  wr_adr,
   input  logic              wr_own_vld,
   input  logic [PID_W-1:0]  wr_own_id,
   input  logic [N_PROC-1:0] wr_copies
);
   logic              own_vld_q [N_LINE];
   logic [PID_W-1:0]  own_id_q  [N_LINE];
   logic [N_PROC-1:0] copies_q  [N_LINE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_LINE; i++) begin
            own_vld_q[i] <= 1'b0;
            own_id_q[i]  <= '0;
            copies_q[i]  <= '0;
         end
      end else if (wr_en) begin
         own_vld_q[wr_adr] <= wr_own_vld;
         own_id_q[wr_adr]  <= wr_own_id;
         copies_q[wr_adr]  <= wr_copies;
      end
   end

   assign rd_own_vld = own_vld_q[rd_adr];
   assign rd_own_id  = own_id_q[rd_adr];
   assign rd_copies  = copies_q[rd_adr];
endmodule

// File: rtl/dircoh_decide.sv
module dircoh_decide #(
   parameter int N_PROC = 4,
   localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input  logic [PID_W-1:0]  req_id,
   input  logic              req_excl,
   input  logic              cur_own_vld,
   input  logic [PID_W-1:0]  cur_own_id,
   input  logic [N_PROC-1:0] cur_copies,
   output logic [N_PROC-1:0] inval_mask,
   output logic              need_mem,
   output logic              need_fwd,
   output logic              fwd_excl,
   output logic              nxt_own_vld,
   output logic [PID_W-1:0]  nxt_own_id,
   output logic [N_PROC-1:0] nxt_copies
);
   logic [N_PROC-1:0] req_bit;
   logic [N_PROC-1:0] own_bit;
   logic              req_is_owner;

   always_comb begin
      req_bit = '0;
      req_bit[req_id] = 1'b1;
      own_bit = '0;
      if (cur_own_vld) own_bit[cur_own_id] = 1'b1;
      req_is_owner = cur_own_vld && (cur_own_id == req_id);

      need_mem = !cur_own_vld;
      need_fwd = cur_own_vld && !req_is_owner;
      fwd_excl = req_excl;

      if (req_excl) begin
         inval_mask  = cur_copies & ~req_bit & ~own_bit;
         nxt_own_vld = 1'b1;
         nxt_own_id  = req_id;
         nxt_copies  = req_bit;
      end else begin
         inval_mask  = '0;
         nxt_own_vld = cur_own_vld;
         nxt_own_id  = cur_own_id;
         nxt_copies  = cur_copies | req_bit;
      end
   end
endmodule

// File: rtl/dircoh_seq.sv
module dircoh_seq
   import dircoh_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int N_LINE = 16,
   localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int ADR_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PID_W-1:0]  req_id,
   input  logic [ADR_W-1:0]  req_adr,
   input  logic [N_PROC-1:0] d_inval,
   input  logic              d_mem,
   input  logic              d_fwd,
   input  logic              d_fex,
   input  logic [PID_W-1:0]  d_own,
   output logic              req_ready,
   output logic              accept,
   output logic              msg_valid,
   output logic [1:0]        msg_kind,
   output logic [PID_W-1:0]  msg_dest,
   output logic [PID_W-1:0]  msg_req,
   output logic [ADR_W-1:0]  msg_adr,
   output logic              dat_valid,
   output logic [PID_W-1:0]  dat_dest,
   output logic [ADR_W-1:0]  dat_adr,
   output logic              cmt_valid,
   output logic [PID_W-1:0]  cmt_dest,
   output logic [ADR_W-1:0]  cmt_adr
);
   seq_state_e        st_q;
   logic [PID_W-1:0]  id_q, own_q, low_idx;
   logic [ADR_W-1:0]  adr_q;
   logic [N_PROC-1:0] mask_q, mask_left;
   logic              mem_q, fwd_q, fex_q;

   assign req_ready = (st_q == SQ_IDLE);
   assign accept    = req_ready && req_valid;

   // lowest pending invalidate target first
   always_comb begin
      low_idx = '0;
      for (int i = N_PROC - 1; i >= 0; i--)
         if (mask_q[i]) low_idx = PID_W'(i);
      mask_left = mask_q;
      mask_left[low_idx] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         id_q   <= '0;
         own_q  <= '0;
         adr_q  <= '0;
         mask_q <= '0;
         mem_q  <= 1'b0;
         fwd_q  <= 1'b0;
         fex_q  <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (accept) begin
               id_q   <= req_id;
               adr_q  <= req_adr;
               own_q  <= d_own;
               mask_q <= d_inval;
               mem_q  <= d_mem;
               fwd_q  <= d_fwd;
               fex_q  <= d_fex;
               if (d_inval != '0)      st_q <= SQ_INV;
               else if (d_mem || d_fwd) st_q <= SQ_DATA;
               else                     st_q <= SQ_CMT;
            end
            SQ_INV: begin
               mask_q <= mask_left;
               if (mask_left == '0) st_q <= (mem_q || fwd_q) ? SQ_DATA : SQ_CMT;
            end
            SQ_DATA: st_q <= SQ_CMT;
            SQ_CMT:  st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MK_FWD_RD;
      msg_dest  = own_q;
      dat_valid = 1'b0;
      cmt_valid = 1'b0;
      if (st_q == SQ_INV) begin
         msg_valid = 1'b1;
         msg_kind  = MK_INVAL;
         msg_dest  = low_idx;
      end else if (st_q == SQ_DATA) begin
         if (mem_q) begin
            dat_valid = 1'b1;
         end else begin
            msg_valid = 1'b1;
            msg_kind  = fex_q ? MK_FWD_EX : MK_FWD_RD;
         end
      end else if (st_q == SQ_CMT) begin
         cmt_valid = 1'b1;
      end
   end

   assign msg_req  = id_q;
   assign msg_adr  = adr_q;
   assign dat_dest = id_q;
   assign dat_adr  = adr_q;
   assign cmt_dest = id_q;
   assign cmt_adr  = adr_q;
endmodule

// File: rtl/dircoh_ctrl.sv
module dircoh_ctrl #(
   parameter int N_PROC = 4,
   parameter int N_LINE = 16,
   localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int ADR_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [PID_W-1:0] req_id,
   input  logic [ADR_W-1:0] req_adr,
   input  logic             req_excl,
   output logic             msg_valid,
   output logic [1:0]       msg_kind,
   output logic [PID_W-1:0] msg_dest,
   output logic [PID_W-1:0] msg_req,
   output logic [ADR_W-1:0] msg_adr,
   output logic             dat_valid,
   output logic [PID_W-1:0] dat_dest,
   output logic [ADR_W-1:0] dat_adr,
   output logic             cmt_valid,
   output logic [PID_W-1:0] cmt_dest,
   output logic [ADR_W-1:0] cmt_adr
);
   generate
      if (N_PROC < 2 || (1 << PID_W) != N_PROC)
         $error("N_PROC must be a power of two, at least 2");
      if (N_LINE < 2 || (1 << ADR_W) != N_LINE)
         $error("N_LINE must be a power of two, at least 2");
   endgenerate

   logic              cur_ov, nxt_ov, d_mem, d_fwd, d_fex, accept;
   logic [PID_W-1:0]  cur_oi, nxt_oi;
   logic [N_PROC-1:0] cur_cp, nxt_cp, d_inval;

   dircoh_store #(.N_PROC(N_PROC), .N_LINE(N_LINE)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_adr(req_adr), .rd_own_vld(cur_ov), .rd_own_id(cur_oi), .rd_copies(cur_cp),
      .wr_en(accept), .wr_adr(req_adr),
      .wr_own_vld(nxt_ov), .wr_own_id(nxt_oi), .wr_copies(nxt_cp)
   );

   dircoh_decide #(.N_PROC(N_PROC)) u_decide (
      .req_id(req_id), .req_excl(req_excl),
      .cur_own_vld(cur_ov), .cur_own_id(cur_oi), .cur_copies(cur_cp),
      .inval_mask(d_inval), .need_mem(d_mem), .need_fwd(d_fwd), .fwd_excl(d_fex),
      .nxt_own_vld(nxt_ov), .nxt_own_id(nxt_oi), .nxt_copies(nxt_cp)
   );

   dircoh_seq #(.N_PROC(N_PROC), .N_LINE(N_LINE)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_id(req_id), .req_adr(req_adr),
      .d_inval(d_inval), .d_mem(d_mem), .d_fwd(d_fwd), .d_fex(d_fex), .d_own(cur_oi),
      .req_ready(req_ready), .accept(accept),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
      .msg_req(msg_req), .msg_adr(msg_adr),
      .dat_valid(dat_valid), .dat_dest(dat_dest), .dat_adr(dat_adr),
      .cmt_valid(cmt_valid), .cmt_dest(cmt_dest), .cmt_adr(cmt_adr)
   );
endmodule

// File: rtl/dircoh_chk.sv
module dircoh_chk #(
   parameter int PID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             msg_valid,
   input logic [1:0]       msg_kind,
   input logic [PID_W-1:0] msg_dest,
   input logic [PID_W-1:0] msg_req,
   input logic             dat_valid,
   input logic             cmt_valid
);
   // R6
   one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({msg_valid, dat_valid, cmt_valid}));

   // R6
   kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_kind != 2'd3));

   // R6
   inval_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 2'd2) |=>
         (!(msg_valid && msg_kind == 2'd2) || (msg_dest > $past(msg_dest))));

   // R6
   commit_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_valid || (msg_valid && msg_kind != 2'd2)) |=> cmt_valid);

   // R4
   no_self_message_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_dest != msg_req));

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R8
   ready_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |=> req_ready);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(msg_valid || dat_valid || cmt_valid));
endmodule

bind dircoh_ctrl dircoh_chk #(.PID_W(PID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
   .msg_req(msg_req), .dat_valid(dat_valid), .cmt_valid(cmt_valid)
);

// File: tb/dircoh_ctrl_tb.sv
`timescale 1ns/1ps
module dircoh_ctrl_tb;
   localparam int NP = 4;
   localparam int NL = 16;
   localparam int PW = 2;
   localparam int AW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_excl = 1'b0;
   logic [PW-1:0] req_id = '0;
   logic [AW-1:0] req_adr = '0;
   logic req_ready, msg_valid, dat_valid, cmt_valid;
   logic [1:0] msg_kind;
   logic [PW-1:0] msg_dest, msg_req, dat_dest, cmt_dest;
   logic [AW-1:0] msg_adr, dat_adr, cmt_adr;

   int checks = 0, failures = 0;
   bit m_ov [NL];
   int m_oi [NL];
   bit [NP-1:0] m_cp [NL];

   always #10 clk = ~clk;

   dircoh_ctrl #(.N_PROC(NP), .N_LINE(NL)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_adr(req_adr), .req_excl(req_excl),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
      .msg_req(msg_req), .msg_adr(msg_adr),
      .dat_valid(dat_valid), .dat_dest(dat_dest), .dat_adr(dat_adr),
      .cmt_valid(cmt_valid), .cmt_dest(cmt_dest), .cmt_adr(cmt_adr)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // word = {chan[2], kind[2], dest[2], adr[4], req[2]}; chan 1 msg, 2 data, 3 commit
   function automatic int pack(int ch, int kd, int ds, int ad, int rq);
      return (ch << 10) | (kd << 8) | (ds << 6) | (ad << 2) | rq;
   endfunction

   task automatic run_req(input int id, input int adr, input bit ex, input string tag);
      int exp_w [8];
      int n = 0;
      bit isown = m_ov[adr] && (m_oi[adr] == id);
      if (ex)
         for (int p = 0; p < NP; p++)
            if (m_cp[adr][p] && p != id && !(m_ov[adr] && p == m_oi[adr])) begin
               exp_w[n] = pack(1, 2, p, adr, id); n++;
            end
      if (!m_ov[adr]) begin
         exp_w[n] = pack(2, 0, id, adr, id); n++;
      end else if (!isown) begin
         exp_w[n] = pack(1, ex ? 1 : 0, m_oi[adr], adr, id); n++;
      end
      exp_w[n] = pack(3, 0, id, adr, id); n++;
      if (ex) begin
         m_ov[adr] = 1'b1; m_oi[adr] = id; m_cp[adr] = '0; m_cp[adr][id] = 1'b1;
      end else begin
         m_cp[adr][id] = 1'b1;
      end

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_id = PW'(id); req_adr = AW'(adr); req_excl = ex;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         int act;
         if (msg_valid)
            act = pack(1, int'(msg_kind), int'(msg_dest), int'(msg_adr), int'(msg_req));
         else if (dat_valid)
            act = pack(2, 0, int'(dat_dest), int'(dat_adr), id);
         else if (cmt_valid)
            act = pack(3, 0, int'(cmt_dest), int'(cmt_adr), id);
         else
            act = 0;
         check(act == exp_w[k], $sformatf("%s R6 msg%0d", tag, k), act, exp_w[k]);
         check(req_ready == 1'b0, $sformatf("%s R8 busy", tag), int'(req_ready), 0);
         if (k + 1 < n) @(negedge clk);
      end
      @(negedge clk);
      check(req_ready && !msg_valid && !dat_valid && !cmt_valid,
            $sformatf("%s R8 idle", tag), int'(req_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unused;
      for (int i = 0; i < NL; i++) begin m_ov[i] = 0; m_oi[i] = 0; m_cp[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !msg_valid && !dat_valid && !cmt_valid, "R1 reset outputs",
            int'({req_ready, msg_valid, dat_valid, cmt_valid}), 8);

      run_req(1, 3, 0, "R1 R2 first read");
      run_req(2, 3, 0, "R2 second read");
      run_req(0, 3, 1, "R4 R5 excl over sharers");
      run_req(3, 3, 0, "R3 read with owner");
      run_req(1, 3, 1, "R4 R5 excl from owner");
      run_req(2, 3, 1, "R9 chain step 1");
      run_req(3, 3, 1, "R9 chain step 2");
      run_req(3, 3, 1, "R7 owner excl again");
      run_req(3, 3, 0, "R7 owner read");
      run_req(0, 3, 0, "R3 read to new owner");
      run_req(3, 3, 1, "R7 owner excl invalidates");
      run_req(0, 4, 0, "R10 untouched line");
      run_req(2, 15, 1, "R1 R10 last line excl");
      run_req(2, 0, 1, "R1 first line excl");

      unused = $urandom(32'd20240611);
      for (int t = 0; t < 400; t++)
         run_req(int'($urandom_range(NP - 1)), int'($urandom_range(3)),
                 bit'($urandom_range(2) == 0), "R6 random");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule